// File: doc/BRIEF.md
# SD/MMC Write Data Path

This block drives the card-facing side of a host's block-write transfer. It takes bytes from a first-word-fall-through data FIFO and shifts them onto a 1-, 4- or 8-lane card data bus. Each block is framed by a start bit and an end bit. After every block the lanes are released and a short status token from the card is read back on lane 0. A negative token is recorded, and the remaining blocks are still sent. A token whose start bit does not arrive in time ends the transfer.

A transfer is launched with a single `start` pulse. The byte count, block size, lane width and auto-stop enable are captured at that moment. A nonzero byte count gives a fixed-length transfer. A byte count of zero gives an open-ended transfer that runs block after block until `abort_req` is seen. For fixed transfers with auto-stop enabled, the block tells the command path when to issue the stop command: during the last block for normal block sizes, or together with the done pulse when the block is too short to hide the stop command. The two error flags stay set until software writes a one to the matching clear bit.

Top module: `sd_wr_path`

## Requirements
- R1: With `bus_width` = 0 (one lane), each block is sent on `dat_out[0]` as one low start bit, then every byte with its most significant bit first, then one high end bit. `dat_oe` is high for exactly these cycles.
- R2: With `bus_width` = 1 (four lanes), each byte takes two cycles on `dat_out[3:0]`, upper nibble first. With `bus_width` = 2 (eight lanes), each byte takes one cycle on `dat_out[7:0]`. In every width the start bit is all active lanes low, the end bit is all active lanes high, and `fifo_rd` pulses once per byte.
- R3: The card's token is read on `dat0_in` as a low start bit, three status bits (most significant first) and an end bit. Status 3'b010 is positive. Any other status sets `err_crc`, and the transfer still sends every remaining byte.
- R4: The token start bit is accepted if `dat0_in` is low in the first or the second cycle after the end bit. If `dat0_in` is high in both cycles, `err_sbit` is set, `done` pulses, no further byte is read and no stop request is made.
- R5: After a token, the next block starts only once `dat0_in` is high. While the card holds it low, the lanes stay released. The gap between the end bit of one block and the start bit of the next block is 6 cycles plus the number of busy cycles.
- R6: For a fixed transfer with `send_stop` set and a block size at or above the width threshold (4, 16 or 32 bytes for 1, 4 or 8 lanes), `stop_req` pulses once, in the cycle that drives the start bit of the last block.
- R7: If the block size is below that threshold, `stop_req` pulses once, in the same cycle as `done`.
- R8: A byte count of 0 makes the transfer open-ended. Blocks of `block_size` bytes repeat until `abort_req` is seen. The block in progress then completes, `done` pulses and no stop request is made.
- R9: `done` is a single-cycle pulse, given once per transfer, after the busy signal that follows the final block is released.
- R10: `err_crc` and `err_sbit` stay set until a one is written to `clr_flags[0]` or `clr_flags[1]` respectively.
- R11: After reset `dat_oe`, `fifo_rd`, `stop_req`, `done`, `err_crc` and `err_sbit` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| byte_count | input | CNT_W | Total bytes to send; 0 selects open-ended |
| block_size | input | BLK_W | Bytes per block, nonzero |
| bus_width | input | 2 | 0 = one lane, 1 = four lanes, 2 = eight lanes |
| send_stop | input | 1 | Request an automatic stop command |
| abort_req | input | 1 | Software stop for the transfer |
| clr_flags | input | 2 | Write-one clear: bit 0 CRC flag, bit 1 start-bit flag |
| fifo_data | input | 8 | Head byte of the write FIFO |
| fifo_rd | output | 1 | Pops the FIFO head |
| dat_out | output | 8 | Card data lanes |
| dat_oe | output | 1 | Lane output enable |
| dat0_in | input | 1 | Sampled card lane 0 |
| stop_req | output | 1 | Ask the command path for the stop command |
| done | output | 1 | Transfer finished pulse |
| err_crc | output | 1 | Negative status token seen |
| err_sbit | output | 1 | Token start bit missing |

## Verification
The assertions assume that configuration inputs hold still for the whole transfer, that `start` arrives only while idle with a nonzero block size, and that the FIFO head is always valid while bytes are being sent. They also assume that the card keeps `dat0_in` high except while it returns a token or signals busy. The bench starts each transfer only after the previous `done`, feeds the FIFO from an endless computed byte sequence, and uses a card model that answers only after the lanes are released. That model can shift its answer by one cycle, withhold it, corrupt the status once, or hold a busy period of a chosen length.

// File: rtl/sd_wr_pkg.sv
package sd_wr_pkg;

  localparam logic [1:0] BW_1 = 2'd0;
  localparam logic [1:0] BW_4 = 2'd1;
  localparam logic [1:0] BW_8 = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_SBIT, S_DATA, S_EBIT, S_TOKEN, S_BUSY, S_DONE
  } wr_state_e;

  // cycles needed to shift one byte out on the selected lane count
  function automatic logic [3:0] beats(input logic [1:0] w);
    case (w)
      BW_1:    return 4'd8;
      BW_4:    return 4'd2;
      default: return 4'd1;
    endcase
  endfunction

  // blocks shorter than this cannot cover the stop command
  function automatic logic [5:0] small_lim(input logic [1:0] w);
    case (w)
      BW_1:    return 6'd4;
      BW_4:    return 6'd16;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [7:0] lane_mask(input logic [1:0] w);
    case (w)
      BW_1:    return 8'h01;
      BW_4:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/sd_wr_serial.sv
module sd_wr_serial
  import sd_wr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] byte_in,
  input  logic [1:0] width,
  output logic [7:0] lanes,
  output logic       last_beat
);

  logic [2:0] beat_q, beat_d;

  assign last_beat = ({1'b0, beat_q} == (beats(width) - 4'd1));

  always_comb begin
    beat_d = beat_q;
    if (!en || last_beat) beat_d = 3'd0;
    else                  beat_d = beat_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     beat_q <= 3'd0;
    else if (en || beat_q != 3'd0)  beat_q <= beat_d;
  end

  always_comb begin
    case (width)
      BW_1:    lanes = {7'd0, byte_in[3'd7 - beat_q]};
      BW_4:    lanes = {4'd0, (beat_q[0] ? byte_in[3:0] : byte_in[7:4])};
      default: lanes = byte_in;
    endcase
  end

  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ({1'b0, beat_q} < beats(width))); // R2

endmodule

// File: rtl/sd_wr_token.sv
module sd_wr_token (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic dat0,
  output logic tok_done,
  output logic tok_ok,
  output logic tok_err
);

  typedef enum logic [1:0] {TK_IDLE, TK_WIN, TK_BITS} tk_state_e;

  tk_state_e  st_q, st_d;
  logic       win_q, win_d;
  logic [1:0] bit_q, bit_d;
  logic [2:0] sh_q, sh_d;

  assign tok_err  = (st_q == TK_WIN) && dat0 && win_q;
  assign tok_done = (st_q == TK_BITS) && (bit_q == 2'd3);
  assign tok_ok   = (sh_q == 3'b010);

  always_comb begin
    st_d  = st_q;
    win_d = win_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    case (st_q)
      TK_IDLE: if (arm) begin
        st_d  = TK_WIN;
        win_d = 1'b0;
      end
      TK_WIN: begin
        if (!dat0) begin
          st_d  = TK_BITS;
          bit_d = 2'd0;
        end else if (win_q) begin
          st_d = TK_IDLE;
        end else begin
          win_d = 1'b1;
        end
      end
      TK_BITS: begin
        if (bit_q == 2'd3) st_d = TK_IDLE;
        else begin
          sh_d  = {sh_q[1:0], dat0};
          bit_d = bit_q + 2'd1;
        end
      end
      default: st_d = TK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TK_IDLE;
      win_q <= 1'b0;
      bit_q <= 2'd0;
      sh_q  <= 3'd0;
    end else begin
      st_q  <= st_d;
      win_q <= win_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TK_WIN && win_q) |=> (st_q != TK_WIN)); // R4

endmodule

// File: rtl/sd_wr_path.sv
module sd_wr_path
  import sd_wr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BLK_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [BLK_W-1:0] block_size,
  input  logic [1:0]       bus_width,
  input  logic             send_stop,
  input  logic             abort_req,
  input  logic [1:0]       clr_flags,
  input  logic [7:0]       fifo_data,
  output logic             fifo_rd,
  output logic [7:0]       dat_out,
  output logic             dat_oe,
  input  logic             dat0_in,
  output logic             stop_req,
  output logic             done,
  output logic             err_crc,
  output logic             err_sbit
);

  localparam int PAD_W = CNT_W - BLK_W;
  localparam int LIM_W = BLK_W - 6;

  wr_state_e        st_q, st_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [BLK_W-1:0] blk_q, blk_d, bsize_q, bsize_d;
  logic [1:0]       width_q, width_d;
  logic             open_q, open_d, small_q, small_d, pend_q, pend_d;
  logic             abort_q, abort_d, crc_q, crc_d, sbit_q, sbit_d;

  logic [7:0] ser_lanes;
  logic       last_beat, tok_done, tok_ok, tok_err;
  logic       last_blk, finish, set_crc, set_sbit;

  sd_wr_serial u_serial (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (st_q == S_DATA),
    .byte_in   (fifo_data),
    .width     (width_q),
    .lanes     (ser_lanes),
    .last_beat (last_beat)
  );

  sd_wr_token u_token (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (st_q == S_EBIT),
    .dat0     (dat0_in),
    .tok_done (tok_done),
    .tok_ok   (tok_ok),
    .tok_err  (tok_err)
  );

  assign last_blk = !open_q && (rem_q <= {{PAD_W{1'b0}}, bsize_q});
  assign finish   = (!open_q && rem_q == '0) || abort_q;
  assign set_crc  = (st_q == S_TOKEN) && tok_done && !tok_ok;
  assign set_sbit = (st_q == S_TOKEN) && tok_err;

  assign fifo_rd  = (st_q == S_DATA) && last_beat;
  assign done     = (st_q == S_DONE);
  assign dat_oe   = (st_q == S_SBIT) || (st_q == S_DATA) || (st_q == S_EBIT);
  assign stop_req = pend_q && (((st_q == S_SBIT) && !small_q && last_blk) ||
                               ((st_q == S_DONE) && small_q));
  assign err_crc  = crc_q;
  assign err_sbit = sbit_q;

  always_comb begin
    case (st_q)
      S_SBIT:  dat_out = 8'h00;
      S_DATA:  dat_out = ser_lanes;
      S_EBIT:  dat_out = lane_mask(width_q);
      default: dat_out = 8'h00;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    rem_d   = rem_q;
    blk_d   = blk_q;
    bsize_d = bsize_q;
    width_d = width_q;
    open_d  = open_q;
    small_d = small_q;
    pend_d  = pend_q;
    abort_d = (st_q == S_IDLE) ? 1'b0 : (abort_q || abort_req);
    case (st_q)
      S_IDLE: if (start) begin
        st_d    = S_SBIT;
        rem_d   = byte_count;
        bsize_d = block_size;
        width_d = bus_width;
        open_d  = (byte_count == '0);
        small_d = block_size < {{LIM_W{1'b0}}, small_lim(bus_width)};
        pend_d  = send_stop && (byte_count != '0);
        if (byte_count == '0 || byte_count >= {{PAD_W{1'b0}}, block_size})
          blk_d = block_size;
        else
          blk_d = byte_count[BLK_W-1:0];
      end
      S_SBIT: begin
        st_d = S_DATA;
        if (stop_req) pend_d = 1'b0;
      end
      S_DATA: if (last_beat) begin
        blk_d = blk_q - BLK_W'(1);
        if (!open_q) rem_d = rem_q - CNT_W'(1);
        if (blk_q == BLK_W'(1)) st_d = S_EBIT;
      end
      S_EBIT: st_d = S_TOKEN;
      S_TOKEN: begin
        if (tok_err) begin
          st_d   = S_DONE;
          pend_d = 1'b0;
        end else if (tok_done) begin
          st_d = S_BUSY;
        end
      end
      S_BUSY: if (dat0_in) begin
        if (finish) st_d = S_DONE;
        else begin
          st_d = S_SBIT;
          if (open_q || rem_q >= {{PAD_W{1'b0}}, bsize_q}) blk_d = bsize_q;
          else                                             blk_d = rem_q[BLK_W-1:0];
        end
      end
      S_DONE: begin
        st_d   = S_IDLE;
        pend_d = 1'b0;
      end
      default: st_d = S_IDLE;
    endcase
    crc_d  = set_crc  || (crc_q  && !clr_flags[0]);
    sbit_d = set_sbit || (sbit_q && !clr_flags[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      rem_q   <= '0;
      blk_q   <= '0;
      bsize_q <= '0;
      width_q <= BW_1;
      open_q  <= 1'b0;
      small_q <= 1'b0;
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
      crc_q   <= 1'b0;
      sbit_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      rem_q   <= rem_d;
      blk_q   <= blk_d;
      bsize_q <= bsize_d;
      width_q <= width_d;
      open_q  <= open_d;
      small_q <= small_d;
      pend_q  <= pend_d;
      abort_q <= abort_d;
      crc_q   <= crc_d;
      sbit_q  <= sbit_d;
    end
  end

  AST_CRC_GOES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TOKEN && tok_done && !tok_ok) |=> (st_q == S_BUSY)); // R3
  AST_SBIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TOKEN && tok_err) |=> done); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BUSY && !dat0_in) |=> (st_q == S_BUSY && !dat_oe)); // R5
  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_crc && !clr_flags[0]) |=> err_crc); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> (!dat_oe && !fifo_rd && !stop_req)); // R11

endmodule

// File: tb/tb_sd_wr_path.sv
module tb_sd_wr_path;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] byte_count = '0;
  logic [11:0] block_size = 12'd1;
  logic [1:0]  bus_width = 2'd0;
  logic        send_stop = 1'b0;
  logic        abort_req = 1'b0;
  logic [1:0]  clr_flags = 2'b00;
  logic [7:0]  fifo_data;
  logic        fifo_rd;
  logic [7:0]  dat_out;
  logic        dat_oe;
  logic        dat0_in = 1'b1;
  logic        stop_req, done, err_crc, err_sbit;

  int checks = 0, errs = 0;
  int fidx = 0;
  int cyc = 0, pops = 0, stops = 0, dones = 0, stop_cyc = -1, done_cyc = -1;
  int pops_at_stop = -1, gap1 = -1, run = 0, cap_n = 0;
  logic stop_oe = 1'b0, seen = 1'b0;
  logic [7:0] cap [0:127];

  int card_delay = 1, card_busy = 0;
  logic card_mute = 1'b0;
  logic [2:0] card_status = 3'b010;

  sd_wr_path dut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .block_size(block_size), .bus_width(bus_width), .send_stop(send_stop),
    .abort_req(abort_req), .clr_flags(clr_flags), .fifo_data(fifo_data),
    .fifo_rd(fifo_rd), .dat_out(dat_out), .dat_oe(dat_oe), .dat0_in(dat0_in),
    .stop_req(stop_req), .done(done), .err_crc(err_crc), .err_sbit(err_sbit)
  );

  function automatic logic [7:0] byte_at(input int i);
    return 8'h3C + 8'(i * 87);
  endfunction

  assign fifo_data = byte_at(fidx);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(posedge clk);
    if (fifo_rd) fidx <= fidx + 1;
  end

  // monitor: samples between edges
  initial forever begin
    @(negedge clk);
    cyc++;
    if (fifo_rd) pops++;
    if (stop_req) begin
      stops++; stop_cyc = cyc; stop_oe = dat_oe; pops_at_stop = pops;
    end
    if (done) begin dones++; done_cyc = cyc; end
    if (dat_oe) begin
      if (cap_n < 128) cap[cap_n] = dat_out;
      cap_n++;
      if (seen && run > 0 && gap1 < 0) gap1 = run;
      run = 0; seen = 1'b1;
    end else if (seen) run++;
  end

  // card model: answers after the lanes are released
  initial begin : card
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (prev && !dat_oe && rst_n) begin
        if (card_mute) card_mute = 1'b0;
        else begin
          if (card_delay == 2) @(negedge clk);
          dat0_in = 1'b0;
          for (int i = 2; i >= 0; i--) begin
            @(negedge clk); dat0_in = card_status[i];
          end
          @(negedge clk); dat0_in = 1'b1;
          card_status = 3'b010;
          for (int i = 0; i < card_busy; i++) begin
            @(negedge clk); dat0_in = 1'b0;
          end
          if (card_busy > 0) begin @(negedge clk); dat0_in = 1'b1; end
        end
      end
      prev = dat_oe;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R9 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk);
    pops = 0; stops = 0; dones = 0; stop_cyc = -1; done_cyc = -1;
    pops_at_stop = -1; gap1 = -1; run = 0; cap_n = 0; seen = 1'b0;
  endtask

  task automatic launch(input logic [15:0] cnt, input logic [11:0] bs,
                        input logic [1:0] w, input logic ss);
    clear_mon();
    @(negedge clk);
    byte_count = cnt; block_size = bs; bus_width = w; send_stop = ss;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (dones == 0 && n < 5000) begin @(posedge clk); n++; end
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 dat_oe", dat_oe, 0);
    chk("R11 fifo_rd", fifo_rd, 0);
    chk("R11 stop_req", stop_req, 0);
    chk("R11 done", done, 0);
    chk("R11 err_crc", err_crc, 0);
    chk("R11 err_sbit", err_sbit, 0);
  endtask

  task automatic t_one_lane_small();
    int base;
    base = fidx;
    launch(16'd2, 12'd2, 2'd0, 1'b1);
    wait_done();
    chk("R1 frame length", cap_n, 18);
    chk("R1 start bit", cap[0][0], 0);
    for (int k = 0; k < 16; k++)
      chk("R1 data bit", cap[1+k][0], byte_at(base + k/8) >> (7 - k%8) & 8'h01);
    chk("R1 end bit", cap[17][0], 1);
    chk("R2 pops", pops, 2);
    chk("R9 done once", dones, 1);
    chk("R7 stop once", stops, 1);
    chk("R7 stop with done", stop_cyc, done_cyc);
    chk("R3 no crc err", err_crc, 0);
  endtask

  task automatic t_four_lane_stop();
    int base;
    base = fidx;
    card_busy = 3;
    launch(16'd32, 12'd16, 2'd1, 1'b1);
    wait_done();
    card_busy = 0;
    chk("R2 frames", cap_n, 68);
    chk("R2 start nibble", cap[0][3:0], 4'h0);
    chk("R2 upper nibble", cap[1][3:0], byte_at(base) >> 4);
    chk("R2 lower nibble", cap[2][3:0], byte_at(base) & 8'h0F);
    chk("R2 end nibble", cap[33][3:0], 4'hF);
    chk("R2 pops", pops, 32);
    chk("R5 busy gap", gap1, 9);
    chk("R6 stop once", stops, 1);
    chk("R6 stop at last start bit", {stop_oe, 8'(pops_at_stop)}, {1'b1, 8'd16});
    chk("R6 stop before done", stop_cyc < done_cyc, 1);
    chk("R9 done once", dones, 1);
  endtask

  task automatic t_neg_crc();
    int base;
    base = fidx;
    card_status = 3'b101;
    launch(16'd4, 12'd2, 2'd2, 1'b0);
    wait_done();
    chk("R3 crc flag", err_crc, 1);
    chk("R3 all bytes sent", pops, 4);
    chk("R2 byte lanes", cap[1], byte_at(base));
    chk("R5 no busy gap", gap1, 6);
    chk("R3 done", dones, 1);
    chk("R4 no sbit flag", err_sbit, 0);
  endtask

  task automatic t_missing_sbit();
    card_mute = 1'b1;
    launch(16'd4, 12'd2, 2'd2, 1'b1);
    wait_done();
    chk("R4 sbit flag", err_sbit, 1);
    chk("R4 stopped after block", pops, 2);
    chk("R4 done", dones, 1);
    chk("R4 no stop request", stops, 0);
  endtask

  task automatic t_clear();
    @(negedge clk); clr_flags = 2'b01;
    @(negedge clk); clr_flags = 2'b00;
    chk("R10 crc cleared", err_crc, 0);
    chk("R10 sbit kept", err_sbit, 1);
    repeat (3) @(negedge clk);
    chk("R10 sbit still kept", err_sbit, 1);
    clr_flags = 2'b10;
    @(negedge clk); clr_flags = 2'b00;
    chk("R10 sbit cleared", err_sbit, 0);
  endtask

  task automatic t_late_sbit();
    card_delay = 2;
    launch(16'd2, 12'd2, 2'd1, 1'b0);
    wait_done();
    card_delay = 1;
    chk("R4 late start bit ok", err_sbit, 0);
    chk("R4 late pops", pops, 2);
    chk("R9 late done", dones, 1);
  endtask

  task automatic t_open();
    launch(16'd0, 12'd3, 2'd2, 1'b1);
    while (pops < 6) @(posedge clk);
    @(negedge clk); abort_req = 1'b1;
    @(negedge clk); abort_req = 1'b0;
    wait_done();
    chk("R8 open pops", pops, 6);
    chk("R8 open done", dones, 1);
    chk("R8 open no stop", stops, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_one_lane_small();
    t_four_lane_stop();
    t_neg_crc();
    t_missing_sbit();
    t_clear();
    t_late_sbit();
    t_open();
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule